// File: doc/BRIEF.md
# SCSI Bus Phase Change Detector

This block watches the three SCSI bus lines that together encode the information-transfer phase (C/D, I/O and MSG) plus the REQ line. It raises a sticky phase-change status bit and drives an interrupt line. Software uses the status bit to learn that a target has moved the bus to a new phase. The bus lines arrive asynchronously and are resynchronized inside the block.

A software mode bit picks how a change is qualified. In "any change" mode, every transition of any phase line counts. In "REQ-qualified" mode, only changes that coincide with REQ count. A change made while REQ is low is held back and reported once REQ asserts, but only if the phase at that point still differs from the phase last reported. In neither mode does the block judge whether the new combination of lines is a legal phase.

The status bit holds until the register interface pulses a clear strobe. An interrupt enable gates the status onto the interrupt line.

Top module: `phase_watch`

## Requirements
- R1: The phase vector is {MSG, C/D, I/O}. A transition on any single one of these three lines counts as a phase change.
- R2: With `qual_any` = 1, every phase change sets the status bit, whatever the level of REQ and whatever the new combination is (every one of the eight combinations is accepted).
- R3: With `qual_any` = 0, a phase change seen while the synchronized REQ is high sets the status bit.
- R4: With `qual_any` = 0, a phase change seen while REQ is low is held pending. When REQ next goes high, the pending change is reported only if the phase then differs from the last reported phase. Otherwise it is discarded.
- R5: A change on REQ alone, with the phase lines steady, never sets the status bit.
- R6: Once set, the status bit stays set until `stat_clr` is pulsed. A pulse in a cycle with no new event clears it at that clock edge.
- R7: When a new event and `stat_clr` fall in the same cycle, the status bit stays set.
- R8: `phase_chg_irq` is a registered copy of the status bit ANDed with `irq_en`. Dropping `irq_en` lowers the interrupt but leaves the status bit unchanged.
- R9: Synchronous reset clears the status bit and the interrupt. It also loads the phase present during reset as the reference, so releasing reset produces no event.
- R10: A phase line change made between two rising edges shows on `phase_chg_stat` after the third rising edge that follows it: two synchronizer stages, then the status register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_cd | input | 1 | C/D line from the bus, asynchronous |
| bus_io | input | 1 | I/O line from the bus, asynchronous |
| bus_msg | input | 1 | MSG line from the bus, asynchronous |
| bus_req | input | 1 | REQ line from the bus, asynchronous |
| qual_any | input | 1 | 1: any phase change counts; 0: REQ-qualified |
| irq_en | input | 1 | Interrupt enable |
| stat_clr | input | 1 | One-cycle strobe that clears the status bit |
| phase_chg_stat | output | 1 | Sticky phase-change status bit |
| phase_chg_irq | output | 1 | Interrupt request |

## Verification
A stale previous-phase or reference register shows up at the port as a missing status bit or a spurious one, three edges after the offending bus change. Stimulus therefore moves one line at a time, with the mode and REQ level chosen to hit each branch. A pending flag that is never cleared, or never set, only shows when REQ next rises. The bench pairs a masked change (phase leaves the reference and then returns to it) with a REQ rise, and checks that nothing fires. The clear-against-event race is exercised in the exact cycle where the two meet, and the latency is pinned by sampling the status one edge before and one edge after it is due.

// File: rtl/scsi_phase_pkg.sv
package scsi_phase_pkg;
  // phase vector bit order: [2]=MSG, [1]=C/D, [0]=I/O
  localparam int PH_W = 3;
  typedef logic [PH_W-1:0] phase_t;

  typedef enum logic {
    QUAL_REQ = 1'b0,
    QUAL_ANY = 1'b1
  } qual_mode_e;
endpackage

// File: rtl/bus_sync.sv
module bus_sync #(
  parameter int WIDTH  = 4,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [WIDTH-1:0] stg [STAGES];

  // Synchronizer flops carry no reset, so data keeps settling while reset is held.
  always_ff @(posedge clk) stg[0] <= d;

  for (genvar i = 1; i < STAGES; i++) begin : g_stage
    always_ff @(posedge clk) stg[i] <= stg[i-1];
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/phase_change_det.sv
module phase_change_det
  import scsi_phase_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  qual_mode_e mode,
  input  phase_t     ph_s,
  input  logic       req_s,
  output logic       evt
);
  phase_t prev_q;   // phase one clock ago
  phase_t rep_q;    // phase at the last reported event
  logic   pend_q;   // change seen while REQ low, not yet reported
  logic   chg;

  always_comb begin
    chg = (ph_s != prev_q);
    if (mode == QUAL_ANY)
      evt = chg;
    else
      evt = req_s && (chg || (pend_q && (ph_s != rep_q)));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      prev_q <= ph_s;
      rep_q  <= ph_s;
      pend_q <= 1'b0;
    end else begin
      prev_q <= ph_s;
      if (evt) rep_q <= ph_s;
      if (mode == QUAL_ANY || req_s)
        pend_q <= 1'b0;
      else if (chg)
        pend_q <= 1'b1;
    end
  end
endmodule

// File: rtl/status_latch.sv
module status_latch (
  input  logic clk,
  input  logic rst,
  input  logic evt,
  input  logic clr,
  input  logic en,
  output logic stat_q,
  output logic irq_q
);
  logic stat_d;

  always_comb begin
    if (evt)      stat_d = 1'b1;   // a new event beats the clear
    else if (clr) stat_d = 1'b0;
    else          stat_d = stat_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      stat_q <= 1'b0;
      irq_q  <= 1'b0;
    end else begin
      stat_q <= stat_d;
      irq_q  <= stat_d & en;
    end
  end
endmodule

// File: rtl/phase_watch.sv
module phase_watch
  import scsi_phase_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic bus_cd,
  input  logic bus_io,
  input  logic bus_msg,
  input  logic bus_req,
  input  logic qual_any,
  input  logic irq_en,
  input  logic stat_clr,
  output logic phase_chg_stat,
  output logic phase_chg_irq
);
  localparam int SW = PH_W + 1;

  logic [SW-1:0] raw_bus;
  logic [SW-1:0] sync_bus;
  phase_t        ph_s;
  logic          req_s;
  logic          evt;
  qual_mode_e    mode;

  assign raw_bus = {bus_msg, bus_cd, bus_io, bus_req};
  assign ph_s    = sync_bus[SW-1:1];
  assign req_s   = sync_bus[0];
  assign mode    = qual_any ? QUAL_ANY : QUAL_REQ;

  bus_sync #(.WIDTH(SW), .STAGES(SYNC_STAGES)) u_sync (
    .clk (clk),
    .d   (raw_bus),
    .q   (sync_bus)
  );

  phase_change_det u_det (
    .clk   (clk),
    .rst   (rst),
    .mode  (mode),
    .ph_s  (ph_s),
    .req_s (req_s),
    .evt   (evt)
  );

  status_latch u_stat (
    .clk    (clk),
    .rst    (rst),
    .evt    (evt),
    .clr    (stat_clr),
    .en     (irq_en),
    .stat_q (phase_chg_stat),
    .irq_q  (phase_chg_irq)
  );
endmodule

// File: rtl/phase_watch_chk.sv
module phase_watch_chk
  import scsi_phase_pkg::*;
(
  input logic   clk,
  input logic   rst,
  input logic   any_mode,
  input logic   stat_clr,
  input logic   req_s,
  input phase_t ph_s,
  input logic   evt,
  input logic   stat,
  input logic   irq
);
  // R2
  a_r2_any_change_sets: assert property (@(posedge clk) disable iff (rst)
    (any_mode && (ph_s != $past(ph_s))) |=> stat);

  // R3
  a_r3_req_change_sets: assert property (@(posedge clk) disable iff (rst)
    (!any_mode && req_s && (ph_s != $past(ph_s))) |=> stat);

  // R5: the status only rises after a detector event
  a_r5_rise_needs_event: assert property (@(posedge clk) disable iff (rst)
    (!stat && !evt) |=> !stat);

  // R6
  a_r6_sticky: assert property (@(posedge clk) disable iff (rst)
    (stat && !stat_clr) |=> stat);

  a_r6_clear: assert property (@(posedge clk) disable iff (rst)
    (stat_clr && !evt) |=> !stat);

  // R7
  a_r7_event_wins: assert property (@(posedge clk) disable iff (rst)
    (evt && stat_clr) |=> stat);

  // R8
  a_r8_irq_needs_stat: assert property (@(posedge clk) disable iff (rst)
    irq |-> stat);

  // R9
  a_r9_reset_clears: assert property (@(posedge clk)
    rst |=> (!stat && !irq));
endmodule

bind phase_watch phase_watch_chk u_chk (
  .clk      (clk),
  .rst      (rst),
  .any_mode (qual_any),
  .stat_clr (stat_clr),
  .req_s    (req_s),
  .ph_s     (ph_s),
  .evt      (evt),
  .stat     (phase_chg_stat),
  .irq      (phase_chg_irq)
);

// File: tb/phase_watch_test.sv
module phase_watch_test;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic bus_cd = 1'b0, bus_io = 1'b0, bus_msg = 1'b0, bus_req = 1'b0;
  logic qual_any = 1'b0, irq_en = 1'b1, stat_clr = 1'b0;
  logic phase_chg_stat, phase_chg_irq;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;  // 125 MHz

  phase_watch uut (
    .clk(clk), .rst(rst), .bus_cd(bus_cd), .bus_io(bus_io),
    .bus_msg(bus_msg), .bus_req(bus_req), .qual_any(qual_any),
    .irq_en(irq_en), .stat_clr(stat_clr),
    .phase_chg_stat(phase_chg_stat), .phase_chg_irq(phase_chg_irq)
  );

  // [8]mode [7]en [6]req [5:3]{msg,cd,io} [2]exp stat [1]exp irq [0]clear after
  localparam int NV = 16;
  localparam logic [8:0] VEC [NV] = '{
    9'b0_1_0_000_0_0_0,  // R5 idle
    9'b0_1_0_011_0_0_0,  // R4 change, REQ low: held
    9'b0_1_1_011_1_1_1,  // R4 REQ rises, differs: reported
    9'b0_1_1_101_1_1_1,  // R3 change while REQ high
    9'b0_1_0_101_0_0_0,  // R5 REQ falls only
    9'b0_1_0_010_0_0_0,  // R4 change held
    9'b0_1_0_101_0_0_0,  // R4 back to reference
    9'b0_1_1_101_0_0_0,  // R4 REQ rises, same phase: dropped
    9'b1_1_1_101_0_0_0,  // R2 mode switch, steady
    9'b1_1_0_101_0_0_0,  // R5 REQ alone in any mode
    9'b1_1_0_111_1_1_0,  // R2 change with REQ low
    9'b1_0_0_111_1_0_1,  // R8 enable off: status kept, irq low
    9'b1_0_0_110_1_0_0,  // R8 new event, irq masked
    9'b1_1_0_110_1_1_1,  // R8 enable back on
    9'b1_1_0_000_1_1_1,  // R2 any combination accepted
    9'b0_1_0_000_0_0_0   // R6 cleared and quiet
  };

  function automatic string vec_req(int i);
    case (i)
      0, 4, 9: return "R5";
      1, 2, 5, 6, 7: return "R4";
      3: return "R3";
      8, 10, 14: return "R2";
      11, 12, 13: return "R8";
      default: return "R6";
    endcase
  endfunction

  task automatic check(string req, string what, logic act, logic exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: got %0b expected %0b", req, what, act, exp);
    end
  endtask

  task automatic report();
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  endtask

  task automatic pulse_clear();
    stat_clr = 1'b1;
    @(negedge clk);
    stat_clr = 1'b0;
    @(negedge clk);
  endtask

  initial begin
    #(8 * 200000);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    report();
  end

  initial begin
    repeat (5) @(negedge clk);
    // R9 reset state
    check("R9", "stat in reset", phase_chg_stat, 1'b0);
    check("R9", "irq in reset", phase_chg_irq, 1'b0);
    rst = 1'b0;
    repeat (2) @(negedge clk);
    check("R9", "stat after release", phase_chg_stat, 1'b0);

    for (int i = 0; i < NV; i++) begin
      qual_any = VEC[i][8];
      irq_en   = VEC[i][7];
      bus_req  = VEC[i][6];
      {bus_msg, bus_cd, bus_io} = VEC[i][5:3];
      repeat (4) @(negedge clk);
      check(vec_req(i), $sformatf("vec%0d stat", i), phase_chg_stat, VEC[i][2]);
      check(vec_req(i), $sformatf("vec%0d irq", i), phase_chg_irq, VEC[i][1]);
      if (VEC[i][0]) begin
        pulse_clear();
        check("R6", $sformatf("vec%0d cleared", i), phase_chg_stat, 1'b0);
      end
    end

    // R1: each single line alone, in any-change mode
    qual_any = 1'b1;
    for (int b = 0; b < 3; b++) begin
      case (b)
        0: bus_io = ~bus_io;
        1: bus_cd = ~bus_cd;
        default: bus_msg = ~bus_msg;
      endcase
      repeat (4) @(negedge clk);
      check("R1", $sformatf("line %0d toggle", b), phase_chg_stat, 1'b1);
      pulse_clear();
    end

    // R10 latency and R7 clear/event collision
    bus_io = ~bus_io;
    @(negedge clk);
    @(negedge clk);
    check("R10", "not yet after two edges", phase_chg_stat, 1'b0);
    stat_clr = 1'b1;
    @(negedge clk);
    stat_clr = 1'b0;
    check("R7", "event beats clear", phase_chg_stat, 1'b1);
    check("R10", "set after third edge", phase_chg_stat, 1'b1);
    pulse_clear();
    check("R6", "clear alone", phase_chg_stat, 1'b0);

    // R9 reset with a new phase present loads it as reference
    rst = 1'b1;
    {bus_msg, bus_cd, bus_io} = 3'b110;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    repeat (5) @(negedge clk);
    check("R9", "no event after reset", phase_chg_stat, 1'b0);
    check("R9", "no irq after reset", phase_chg_irq, 1'b0);

    report();
  end
endmodule